// File: doc/BRIEF.md
# Bank-Pair GPIO Data Register File

This block holds the data-path state for two 16-pin general-purpose I/O banks that share one set of 32-bit registers. The lower bank occupies bits 15:0 of every register and the upper bank occupies bits 31:16. Software configures each pin as an input or an output through a direction register. It drives output levels through an output latch, which can be changed in three ways: a write that replaces the whole word, a write-1-to-set word, or a write-1-to-clear word. The set and clear words let independent software tasks flip their own pins without a read-modify-write sequence and without masking interrupts.

The latch reads back the drive state rather than the pin level. The input register, fed through a two-stage synchronizer, reports the actual pin level whatever the direction. Together these allow wired logic: software can compare what it drives with what the pin actually carries. The register bus is a plain synchronous port: address, write enable, write data, and a registered read-data word valid one cycle after the address is presented. It has no handshake. Each access completes in one cycle.

Top module: `gpio_pair_regfile`

## Requirements
- R1: After reset, every direction bit is 1 (all pins are inputs), the output latch is 0, `pin_oe` and `pin_out` are 0, and the first registered read returns 0.
- R2: A write to byte offset 0x00 loads the direction word. Bit value 1 means input and 0 means output. `pin_oe` is the bitwise inverse of the direction word, and reading 0x00 returns the word.
- R3: A write to byte offset 0x04 replaces all 32 latch bits, covering both banks.
- R4: A write to byte offset 0x08 drives high every latch bit written as 1 and leaves the bits written as 0 unchanged.
- R5: A write to byte offset 0x0C drives low every latch bit written as 1 and leaves the bits written as 0 unchanged.
- R6: Reads of offsets 0x04, 0x08 and 0x0C all return the output latch, never the pin level.
- R7: `pin_out` carries a latch bit only where that pin is an output and is 0 elsewhere. The latch keeps its value while a pin is an input.
- R8: Reading offset 0x10 returns the pin levels after two synchronizer stages, whatever the direction. A pin change made just before an edge appears in read data at the third edge.
- R9: Read data is registered. It reflects the state before any write in the same cycle, and the new value appears one cycle later.
- R10: Writes to offset 0x10 and to the unused offsets 0x14, 0x18 and 0x1C change nothing. Reads of the unused offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Byte address of the register; bits 1:0 are ignored |
| bus_we | input | 1 | Write enable for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| pin_in | input | 32 | Pin levels from the pads |
| pin_out | output | 32 | Output level per pin |
| pin_oe | output | 32 | Output enable per pin, 1 = drive |

## Verification
A write and a read of the same register can fall in the same cycle, because the bus carries one address for both. The bench provokes this by writing new data to the output latch while the read data is being captured from that same offset. It judges the result by requiring the pre-write latch in that cycle and the written word one cycle later, while `pin_out` already shows the new value. A second coincidence is a pin change while the input register is being read. This is judged by counting edges: the old level must still be read after two edges, and the new level after three.

// File: rtl/gpio_pair_pkg.sv
package gpio_pair_pkg;
  localparam int unsigned PINS_PER_BANK = 16;
  localparam int unsigned BANKS_PER_REG = 2;
  localparam int unsigned REG_W         = PINS_PER_BANK * BANKS_PER_REG;

  typedef enum logic [2:0] {
    SEL_DIR = 3'd0,
    SEL_OUT = 3'd1,
    SEL_SET = 3'd2,
    SEL_CLR = 3'd3,
    SEL_IN  = 3'd4
  } reg_sel_e;

  localparam int unsigned LAST_WORD = 4;
endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
  import gpio_pair_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output logic              wr_dir,
  output logic              wr_out,
  output logic              wr_set,
  output logic              wr_clr,
  output logic              rd_hit,
  output reg_sel_e          rd_sel
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic [1:0]       unused_byte_lane;

  assign idx              = addr[ADDR_W-1:2];
  assign unused_byte_lane = addr[1:0];

  always_comb begin
    rd_hit = (idx <= IDX_W'(LAST_WORD));
    rd_sel = SEL_DIR;
    if (rd_hit) rd_sel = reg_sel_e'(idx[2:0]);
  end

  assign wr_dir = we && rd_hit && (rd_sel == SEL_DIR);
  assign wr_out = we && rd_hit && (rd_sel == SEL_OUT);
  assign wr_set = we && rd_hit && (rd_sel == SEL_SET);
  assign wr_clr = we && rd_hit && (rd_sel == SEL_CLR);
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_dir,
  input  logic         wr_out,
  input  logic         wr_set,
  input  logic         wr_clr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] lat_q
);
  logic [W-1:0] set_mask;
  logic [W-1:0] clr_mask;
  logic [W-1:0] lat_d;

  assign set_mask = wr_set ? wdata : '0;
  assign clr_mask = wr_clr ? wdata : '0;

  // Clear is applied after set, so a clash on one bit ends low.
  always_comb begin
    if (wr_out) lat_d = wdata;
    else        lat_d = (lat_q | set_mask) & ~clr_mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= '1;
      lat_q <= '0;
    end else begin
      if (wr_dir) dir_q <= wdata;
      lat_q <= lat_d;
    end
  end

  a_r2_dir_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir |=> $stable(dir_q));
  a_r3_direct_replace: assert property (@(posedge clk) disable iff (!rst_n)
    wr_out |=> (lat_q == $past(wdata)));
  a_r4_set_high: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> (((lat_q & $past(wdata)) == $past(wdata)) &&
                ((lat_q & ~$past(wdata)) == ($past(lat_q) & ~$past(wdata)))));
  a_r5_clear_low: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> (((lat_q & $past(wdata)) == '0) &&
                ((lat_q & ~$past(wdata)) == ($past(lat_q) & ~$past(wdata)))));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] level_q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= pin_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign level_q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pair_regfile.sv
module gpio_pair_regfile
  import gpio_pair_pkg::*;
#(
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [REG_W-1:0]  pin_in,
  output logic [REG_W-1:0]  pin_out,
  output logic [REG_W-1:0]  pin_oe
);
  logic             wr_dir, wr_out, wr_set, wr_clr, rd_hit;
  reg_sel_e         rd_sel;
  logic [REG_W-1:0] dir_q, lat_q, level_q, rd_mux;

  gpio_bus_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr   (bus_addr),
    .we     (bus_we),
    .wr_dir (wr_dir),
    .wr_out (wr_out),
    .wr_set (wr_set),
    .wr_clr (wr_clr),
    .rd_hit (rd_hit),
    .rd_sel (rd_sel)
  );

  gpio_out_latch #(.W(REG_W)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_dir (wr_dir),
    .wr_out (wr_out),
    .wr_set (wr_set),
    .wr_clr (wr_clr),
    .wdata  (bus_wdata),
    .dir_q  (dir_q),
    .lat_q  (lat_q)
  );

  gpio_in_sync #(.W(REG_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_in  (pin_in),
    .level_q (level_q)
  );

  assign pin_oe  = ~dir_q;
  assign pin_out = lat_q & ~dir_q;

  always_comb begin
    rd_mux = '0;
    if (rd_hit) begin
      unique case (rd_sel)
        SEL_DIR:                   rd_mux = dir_q;
        SEL_OUT, SEL_SET, SEL_CLR: rd_mux = lat_q;
        SEL_IN:                    rd_mux = level_q;
        default:                   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_mux;
  end

  a_r10_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (bus_addr[ADDR_W-1:2] >= (ADDR_W-2)'(LAST_WORD)))
    |=> ($stable(lat_q) && $stable(dir_q)));
  a_r7_no_drive_on_input: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pin_oe[0]) |-> !pin_out[0]);
  a_r9_read_old_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && rd_sel == SEL_OUT) |=> (bus_rdata == $past(lat_q)));
endmodule

// File: tb/gpio_pair_regfile_test.sv
module gpio_pair_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  b_addr = '0;
  logic        b_we = 1'b0;
  logic [31:0] b_wd = '0;
  logic [31:0] b_rd, p_in, p_out, p_oe;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic [31:0] m_dir, m_lat;

  always #4 clk = ~clk;

  gpio_pair_regfile uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_we(b_we),
    .bus_wdata(b_wd), .bus_rdata(b_rd), .pin_in(p_in),
    .pin_out(p_out), .pin_oe(p_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    b_addr = a; b_we = 1'b1; b_wd = d;
    @(posedge clk); @(negedge clk);
    b_we = 1'b0;
    case (a)
      5'h00: m_dir = d;
      5'h04: m_lat = d;
      5'h08: m_lat = m_lat | d;
      5'h0C: m_lat = m_lat & ~d;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    b_addr = a; b_we = 1'b0;
    @(posedge clk); @(negedge clk);
    v = b_rd;
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] x);
    return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
  endfunction

  task automatic check_pins(input string req);
    check({req, " pin_oe"}, p_oe, ~m_dir);
    check({req, " pin_out"}, p_out, m_lat & ~m_dir);
  endtask

  initial begin
    logic [31:0] v, seed;
    p_in = '0;
    m_dir = '1; m_lat = '0;
    repeat (3) @(negedge clk);
    check("R1 rdata in reset", b_rd, 32'h0);
    rst_n = 1'b1;
    check("R1 oe", p_oe, 32'h0);
    check("R1 out", p_out, 32'h0);
    rd(5'h00, v); check("R1 dir reset", v, 32'hFFFF_FFFF);
    rd(5'h04, v); check("R1 latch reset", v, 32'h0);

    // R2 and R7: direction patterns with latch held, then sweep
    wr(5'h04, 32'hA5C3_5A3C);
    seed = 32'h1357_9BDF;
    for (int i = 0; i < 40; i++) begin
      seed = nxt(seed);
      wr(5'h00, seed);
      check_pins("R2 R7");
      rd(5'h00, v); check("R2 dir readback", v, m_dir);
      rd(5'h04, v); check("R7 latch kept under inputs", v, m_lat);
    end
    wr(5'h00, 32'h0000_FFFF); check_pins("R7 upper bank out");
    wr(5'h00, 32'hFFFF_0000); check_pins("R7 lower bank out");
    wr(5'h00, 32'h0);

    // R3: direct writes
    for (int i = 0; i < 40; i++) begin
      seed = nxt(seed);
      wr(5'h04, seed);
      check_pins("R3");
      rd(5'h04, v); check("R3 direct readback", v, m_lat);
    end

    // R4 R5 R6: per-bit set and clear sweeps
    wr(5'h04, 32'h0);
    for (int b = 0; b < 32; b++) begin
      wr(5'h08, 32'h1 << b);
      rd(5'h08, v); check("R4 R6 single set", v, m_lat);
    end
    for (int b = 0; b < 32; b++) begin
      wr(5'h0C, 32'h1 << b);
      rd(5'h0C, v); check("R5 R6 single clear", v, m_lat);
      check_pins("R5");
    end
    for (int i = 0; i < 60; i++) begin
      seed = nxt(seed);
      if (seed[7]) wr(5'h08, seed); else wr(5'h0C, seed);
      check_pins("R4 R5 mixed");
      rd(5'h04, v); check("R4 R5 mixed readback", v, m_lat);
    end

    // R6: latch readback differs from pin level
    p_in = ~m_lat;
    repeat (3) @(negedge clk);
    rd(5'h04, v); check("R6 out not pin", v, m_lat);
    rd(5'h08, v); check("R6 set not pin", v, m_lat);
    rd(5'h0C, v); check("R6 clr not pin", v, m_lat);

    // R8: synchronizer latency, both directions
    for (int i = 0; i < 20; i++) begin
      logic [31:0] old_p;
      seed = nxt(seed);
      wr(5'h00, (i % 2 == 0) ? 32'h0 : 32'hFFFF_FFFF);
      rd(5'h10, v);
      old_p = p_in;
      p_in = seed;
      b_addr = 5'h10;
      @(posedge clk); @(negedge clk);
      @(posedge clk); @(negedge clk);
      check("R8 old level after two edges", b_rd, old_p);
      @(posedge clk); @(negedge clk);
      check("R8 new level after three edges", b_rd, seed);
    end

    // R9: same-cycle write and read of the latch
    wr(5'h00, 32'h0);
    wr(5'h04, 32'h1111_2222);
    b_addr = 5'h04; b_we = 1'b1; b_wd = 32'hDEAD_BEEF;
    @(posedge clk); @(negedge clk);
    b_we = 1'b0; m_lat = 32'hDEAD_BEEF;
    check("R9 old value in write cycle", b_rd, 32'h1111_2222);
    check("R9 pin_out already new", p_out, 32'hDEAD_BEEF);
    @(posedge clk); @(negedge clk);
    check("R9 new value next cycle", b_rd, 32'hDEAD_BEEF);

    // R10: ignored writes and zero reads
    for (int a = 4; a < 8; a++) begin
      wr(5'(a * 4), 32'h5555_AAAA ^ 32'(a));
      rd(5'h04, v); check("R10 latch untouched", v, m_lat);
      rd(5'h00, v); check("R10 dir untouched", v, m_dir);
      check_pins("R10");
      if (a > 4) begin
        rd(5'(a * 4), v); check("R10 unused reads zero", v, 32'h0);
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule